// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects thirteen interrupt sources and presents them to a processor as eight vectors, with three priority tiers and nested service. Four of the sources are external pins, each with a programmable trigger condition. The other nine are single-cycle request pulses from on-chip peripherals. Several sources share one vector, and the interrupt handler tells them apart in software.

Each vector has an enable bit and a priority-select bit. The block raises `irq` together with a vector address whenever an enabled, pending vector has a priority strictly above the level now in service. The processor pulses `ack` to enter the handler and pulses `ret` to leave it. The block keeps a record of every nested level, so each return restores the level that was interrupted.

The pins pass through one register stage. Edge detection compares that registered copy with a second register. An edge request is latched and held until it is acknowledged. A level request is live only while the pin holds its active level.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, `irq` is 0 and `cur_level` is 0 (no level in service).
- R2: Vector v has the address 8*v+3. The sources map onto vectors as follows:
  - pin 0 goes to v0, and pin 1 goes to v1.
  - pin 2 and `src_pulse[0]` go to v2.
  - pin 3 and `src_pulse[1]` go to v3.
  - `src_pulse[2]` goes to v4.
  - `src_pulse[3]` and `src_pulse[4]` go to v5.
  - `src_pulse[5]` and `src_pulse[6]` go to v6.
  - `src_pulse[7]` and `src_pulse[8]` go to v7.
- R3: The trigger for pins 0 and 1 is set by `pin_mode[2p+1:2p]`: 00 is the rising edge, 01 the falling edge, 10 a high level and 11 a low level. An edge that does not match the selected mode creates no request.
- R4: The trigger for pins 2 and 3 is set by `pin_mode[2p+1:2p]`: 00 is the rising edge, 01 the falling edge, and 1x both edges.
- R5: The request level is coded 1 for low, 2 for high and 3 for highest. For v0 and v1, `pri_sel[v]`=1 selects highest and 0 selects low. For v2 to v7, 1 selects high and 0 selects low. `cur_level` reports 0 to 3.
- R6: A vector is offered only if its level is strictly greater than `cur_level`. Among offered vectors the highest level wins, and on equal levels the lower vector number wins.
- R7: An acknowledge while `irq` is 1 sets `cur_level` to the granted level and clears the latched edge request. On a shared vector it clears only the first source listed in R2 that is pending, and the other source stays pending.
- R8: A level-mode pin requests only while it holds its active level. When the level goes away, the request is withdrawn without an acknowledge.
- R9: A `ret` pulse restores the level that was in service before the last acknowledge. A `ret` with nothing in service has no effect. When `ack` (with `irq` 1) and `ret` arrive in the same cycle, the acknowledge wins.
- R10: A vector whose `vec_en` bit is 0 never raises `irq`. Its edge requests still latch, and they are offered once the vector is enabled.
- R11: A higher-level request preempts a handler that is running, and nesting goes up to three levels deep.
- R12: An `ack` while `irq` is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 4 | Raw external interrupt pins |
| pin_mode | input | 8 | Trigger mode, two bits per pin |
| src_pulse | input | 9 | Single-cycle peripheral request pulses |
| vec_en | input | 8 | Enable for each vector |
| pri_sel | input | 8 | Priority select for each vector |
| ack | input | 1 | Processor accepts the offered vector |
| ret | input | 1 | Processor returns from the current handler |
| irq | output | 1 | Interrupt request to the processor |
| vec_addr | output | ADDR_W | Address of the offered vector |
| cur_level | output | 2 | Level now in service (0 = none) |

## Verification
Faults in the latched requests or in the level record show up at the ports within one or two cycles:
- A flag that is not cleared on acknowledge shows as `irq` returning with the same address right after the following `ret`.
- A flag that is lost shows as `irq` staying low one cycle after a pulse, or two cycles after a pin edge.
- A corrupted level record shows at once on `cur_level` after `ack` or `ret`. It also shows as a request of equal or lower level being offered, or a higher one being withheld.

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl #(
  parameter int ADDR_W     = 8,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        ext_pin,
  input  logic [7:0]        pin_mode,
  input  logic [8:0]        src_pulse,
  input  logic [7:0]        vec_en,
  input  logic [7:0]        pri_sel,
  input  logic              ack,
  input  logic              ret,
  output logic              irq,
  output logic [ADDR_W-1:0] vec_addr,
  output logic [1:0]        cur_level
);

  logic [3:0] pin_q, pin_qq, pin_flag, pin_evt, pin_clr;
  logic [8:0] src_flag, src_clr;
  logic [2:0] svc, svc_pop;
  logic [1:0] lvl_mode, lvl_act;
  logic [7:0] vec_pend;
  logic [7:0][1:0] vec_lvl;
  logic [2:0] best;
  logic [1:0] best_lvl;
  logic       grant;

  wire [3:0] rise = pin_q & ~pin_qq;
  wire [3:0] fall = ~pin_q & pin_qq;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pin_q  <= '0;
      pin_qq <= '0;
    end else begin
      pin_q  <= ext_pin;
      pin_qq <= pin_q;
    end

  for (genvar p = 0; p < 2; p++) begin : g_lvlpin
    assign lvl_mode[p]  = pin_mode[2*p+1];
    assign lvl_act[p]   = pin_mode[2*p] ? ~pin_q[p] : pin_q[p];
    assign pin_evt[p]   = ~pin_mode[2*p+1] & (pin_mode[2*p] ? fall[p] : rise[p]);
  end

  for (genvar p = 2; p < 4; p++) begin : g_edgepin
    assign pin_evt[p] = pin_mode[2*p+1] ? (rise[p] | fall[p])
                                        : (pin_mode[2*p] ? fall[p] : rise[p]);
  end

  assign vec_pend[0] = lvl_mode[0] ? lvl_act[0] : pin_flag[0];
  assign vec_pend[1] = lvl_mode[1] ? lvl_act[1] : pin_flag[1];
  assign vec_pend[2] = pin_flag[2] | src_flag[0];
  assign vec_pend[3] = pin_flag[3] | src_flag[1];
  assign vec_pend[4] = src_flag[2];
  assign vec_pend[5] = src_flag[3] | src_flag[4];
  assign vec_pend[6] = src_flag[5] | src_flag[6];
  assign vec_pend[7] = src_flag[7] | src_flag[8];

  for (genvar v = 0; v < 8; v++) begin : g_lvl
    if (v < 2) begin : g_top
      assign vec_lvl[v] = pri_sel[v] ? 2'd3 : 2'd1;
    end else begin : g_mid
      assign vec_lvl[v] = pri_sel[v] ? 2'd2 : 2'd1;
    end
  end

  assign cur_level = svc[2] ? 2'd3 : svc[1] ? 2'd2 : svc[0] ? 2'd1 : 2'd0;
  assign svc_pop   = svc[2] ? {1'b0, svc[1:0]} : svc[1] ? {2'b00, svc[0]} : 3'b000;

  always_comb begin
    best_lvl = cur_level;
    best     = '0;
    irq      = 1'b0;
    for (int v = 0; v < 8; v++)
      if (vec_en[v] && vec_pend[v] && vec_lvl[v] > best_lvl) begin
        best_lvl = vec_lvl[v];
        best     = 3'(v);
        irq      = 1'b1;
      end
  end

  assign vec_addr = ADDR_W'(VEC_BASE + VEC_STRIDE * int'(best));
  assign grant    = ack & irq;

  always_comb begin
    pin_clr = '0;
    src_clr = '0;
    if (grant)
      case (best)
        3'd0: pin_clr[0] = 1'b1;
        3'd1: pin_clr[1] = 1'b1;
        3'd2: if (pin_flag[2]) pin_clr[2] = 1'b1; else src_clr[0] = 1'b1;
        3'd3: if (pin_flag[3]) pin_clr[3] = 1'b1; else src_clr[1] = 1'b1;
        3'd4: src_clr[2] = 1'b1;
        3'd5: if (src_flag[3]) src_clr[3] = 1'b1; else src_clr[4] = 1'b1;
        3'd6: if (src_flag[5]) src_clr[5] = 1'b1; else src_clr[6] = 1'b1;
        default: if (src_flag[7]) src_clr[7] = 1'b1; else src_clr[8] = 1'b1;
      endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pin_flag <= '0;
      src_flag <= '0;
      svc      <= '0;
    end else begin
      pin_flag <= ((pin_flag & ~pin_clr) | pin_evt) & ~{2'b00, lvl_mode};
      src_flag <= (src_flag & ~src_clr) | src_pulse;
      if (grant)
        svc[best_lvl - 2'd1] <= 1'b1;
      else if (ret)
        svc <= svc_pop;
    end

endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq,
  input logic              ack,
  input logic              ret,
  input logic [ADDR_W-1:0] vec_addr,
  input logic [7:0]        vec_en,
  input logic [1:0]        cur_level
);

  AST_ADDR_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (vec_addr[2:0] == 3'b011 && vec_addr <= ADDR_W'(59)));  // R2

  AST_ACK_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq) |=> cur_level > $past(cur_level));  // R7

  AST_RET_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && !(ack && irq) && cur_level != 2'd0) |=> cur_level < $past(cur_level));  // R9

  AST_IDLE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !irq && !ret) |=> cur_level == $past(cur_level));  // R12

  AST_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_en == 8'h00) |-> !irq);  // R10

  AST_TOP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_level == 2'd3) |-> !irq);  // R6

endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .ack(ack), .ret(ret),
  .vec_addr(vec_addr), .vec_en(vec_en), .cur_level(cur_level)
);

// File: tb/tb_irq_vec_ctrl.sv
module tb_irq_vec_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] ext_pin = '0;
  logic [7:0] pin_mode = '0;
  logic [8:0] src_pulse = '0;
  logic [7:0] vec_en = 8'hFF;
  logic [7:0] pri_sel = '0;
  logic       ack = 1'b0;
  logic       ret = 1'b0;
  logic       irq;
  logic [7:0] vec_addr;
  logic [1:0] cur_level;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_vec_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .pin_mode(pin_mode),
    .src_pulse(src_pulse), .vec_en(vec_en), .pri_sel(pri_sel),
    .ack(ack), .ret(ret), .irq(irq), .vec_addr(vec_addr), .cur_level(cur_level)
  );

  function automatic int vaddr(int v);
    return 8 * v + 3;
  endfunction

  function automatic int src_vec(int i);
    case (i)
      0: return 2;
      1: return 3;
      2: return 4;
      3, 4: return 5;
      5, 6: return 6;
      default: return 7;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_ack;
    ack = 1'b1; step(1); ack = 1'b0;
  endtask

  task automatic do_ret;
    ret = 1'b1; step(1); ret = 1'b0;
  endtask

  task automatic pulse(int i);
    src_pulse[i] = 1'b1; step(1); src_pulse = '0;
  endtask

  task automatic expect_vec(string tag, int v);
    chk(irq == 1'b1, {tag, " irq"}, int'(irq), 1);
    chk(int'(vec_addr) == vaddr(v), {tag, " addr"}, int'(vec_addr), vaddr(v));
  endtask

  task automatic t_reset;
    chk(irq == 1'b0, "R1 irq after reset", int'(irq), 0);
    chk(cur_level == 2'd0, "R1 level after reset", int'(cur_level), 0);
  endtask

  task automatic t_map;
    for (int i = 0; i < 9; i++) begin
      pulse(i);
      expect_vec("R2 source map", src_vec(i));
      do_ack;
      chk(cur_level == 2'd1, "R7 level on ack", int'(cur_level), 1);
      do_ret;
      chk(cur_level == 2'd0, "R9 level on ret", int'(cur_level), 0);
      chk(irq == 1'b0, "R7 flag cleared", int'(irq), 0);
    end
  endtask

  task automatic t_pin01;
    ext_pin[0] = 1'b1; step(1);
    chk(irq == 1'b0, "R3 rise not yet latched", int'(irq), 0);
    step(1);
    expect_vec("R3 pin0 rise", 0);
    do_ack; do_ret;
    ext_pin[0] = 1'b0; step(2);
    chk(irq == 1'b0, "R3 fall ignored in rise mode", int'(irq), 0);
    pin_mode[3:2] = 2'b01;
    ext_pin[1] = 1'b1; step(2);
    chk(irq == 1'b0, "R3 rise ignored in fall mode", int'(irq), 0);
    ext_pin[1] = 1'b0; step(2);
    expect_vec("R3 pin1 fall", 1);
    do_ack; do_ret;
    pin_mode[1:0] = 2'b10;
    ext_pin[0] = 1'b1; step(1);
    expect_vec("R8 pin0 high level", 0);
    ext_pin[0] = 1'b0; step(1);
    chk(irq == 1'b0, "R8 level withdrawn", int'(irq), 0);
    pin_mode[3:2] = 2'b11; step(1);
    expect_vec("R3 pin1 low level", 1);
    do_ack;
    chk(irq == 1'b0, "R6 equal level held off", int'(irq), 0);
    ext_pin[1] = 1'b1; step(1);
    do_ret;
    chk(irq == 1'b0, "R8 inactive after return", int'(irq), 0);
    pin_mode = '0; step(2);
    ext_pin[1] = 1'b0; step(2);
  endtask

  task automatic t_pin23;
    pin_mode[5:4] = 2'b10;
    ext_pin[2] = 1'b1; step(2);
    expect_vec("R4 pin2 both rise", 2);
    do_ack; do_ret;
    ext_pin[2] = 1'b0; step(2);
    expect_vec("R4 pin2 both fall", 2);
    do_ack; do_ret;
    pin_mode[7:6] = 2'b01;
    ext_pin[3] = 1'b1; step(2);
    chk(irq == 1'b0, "R4 pin3 rise ignored", int'(irq), 0);
    ext_pin[3] = 1'b0; step(2);
    expect_vec("R4 pin3 fall", 3);
    do_ack; do_ret;
    pin_mode = '0;
  endtask

  task automatic t_priority;
    src_pulse = 9'b0_0000_1100; step(1); src_pulse = '0;
    expect_vec("R6 tie lower vector", 4);
    do_ack;
    chk(irq == 1'b0, "R6 equal level not offered", int'(irq), 0);
    do_ret;
    expect_vec("R6 loser after return", 5);
    do_ack; do_ret;
    pri_sel[5] = 1'b1;
    src_pulse = 9'b0_0000_1100; step(1); src_pulse = '0;
    expect_vec("R5 high beats low", 5);
    do_ack;
    chk(cur_level == 2'd2, "R5 high level code", int'(cur_level), 2);
    chk(irq == 1'b0, "R6 low held under high", int'(irq), 0);
    do_ret;
    expect_vec("R6 low after high", 4);
    do_ack; do_ret;
    pri_sel = '0;
  endtask

  task automatic t_nest;
    pulse(0); do_ack;
    pri_sel[5] = 1'b1;
    pulse(3);
    expect_vec("R11 high preempts low", 5);
    do_ack;
    chk(cur_level == 2'd2, "R11 nested level 2", int'(cur_level), 2);
    pri_sel[0] = 1'b1;
    ext_pin[0] = 1'b1; step(2);
    expect_vec("R11 highest preempts high", 0);
    do_ack;
    chk(cur_level == 2'd3, "R5 highest level code", int'(cur_level), 3);
    pri_sel[7] = 1'b1;
    pulse(7);
    chk(irq == 1'b0, "R6 high under highest", int'(irq), 0);
    do_ret;
    chk(cur_level == 2'd2, "R9 restore level 2", int'(cur_level), 2);
    chk(irq == 1'b0, "R6 high under high", int'(irq), 0);
    do_ret;
    chk(cur_level == 2'd1, "R9 restore level 1", int'(cur_level), 1);
    expect_vec("R6 high above low", 7);
    do_ack; do_ret; do_ret;
    chk(cur_level == 2'd0, "R9 restore none", int'(cur_level), 0);
    ext_pin[0] = 1'b0; step(2);
    pri_sel = '0;
  endtask

  task automatic t_shared;
    src_pulse = 9'b0_0001_1000; step(1); src_pulse = '0;
    expect_vec("R7 shared vector", 5);
    do_ack; do_ret;
    expect_vec("R7 second source kept", 5);
    do_ack; do_ret;
    chk(irq == 1'b0, "R7 both sources served", int'(irq), 0);
  endtask

  task automatic t_enable;
    vec_en = '0;
    pulse(2); step(2);
    chk(irq == 1'b0, "R10 masked vector silent", int'(irq), 0);
    vec_en = 8'hFF; step(1);
    expect_vec("R10 held request offered", 4);
    do_ack; do_ret;
  endtask

  task automatic t_idle;
    do_ack;
    chk(cur_level == 2'd0, "R12 ack without irq", int'(cur_level), 0);
    do_ret;
    chk(cur_level == 2'd0, "R9 ret with none in service", int'(cur_level), 0);
    pulse(0);
    ack = 1'b1; ret = 1'b1; step(1); ack = 1'b0; ret = 1'b0;
    chk(cur_level == 2'd1, "R9 ack wins over ret", int'(cur_level), 1);
    do_ret;
    chk(cur_level == 2'd0, "R9 final return", int'(cur_level), 0);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset;
    t_map;
    t_pin01;
    t_pin23;
    t_priority;
    t_nest;
    t_shared;
    t_enable;
    t_idle;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule